// File: doc/BRIEF.md
# SIMT Execution Mask Control Unit

This block holds the per-lane live execution mask of a 64-lane SIMD machine, where one scalar unit predicates every vector lane. A lane does its vector work only while its mask bit is set. Divergent if/else regions and loops are expressed as save-and-modify operations on this mask and on a small file of 64-bit saved-mask registers. There is no hardware reconvergence stack: software keeps the lanes that are parked in ordinary saved-mask registers and restores them at the end of a region.

Each cycle the block accepts one decoded mask operation, a per-lane condition mask produced by vector compares, a destination register index and a source register index. It updates the live mask and at most one saved register in a single clock. A combinational branch-taken flag serves loop-back branches (taken while any lane remains live) and skip branches (taken when no lane is live). A read index brings any saved register out for the scalar side.

Top module: `emask_ctrl`

## Requirements
- R1: On reset (rst_ni low) the live mask exec_o is all ones and every saved-mask register reads zero.
- R2: Operation code 1 (enter-if) sets the live mask to cond_i AND the old live mask, and writes the old live lanes that failed the condition (old mask AND NOT cond_i) into register dst_i.
- R3: Operation code 2 (else) forms the old live mask OR register src_i, writes that result to register dst_i, and sets the live mask to that result XOR the old live mask.
- R4: Operation code 3 (end-region) sets the live mask to the old live mask OR register src_i and writes no register.
- R5: Operation code 4 (break) writes the live mask OR register src_i into register dst_i and leaves the live mask unchanged.
- R6: Operation code 5 (conditional break) writes cond_i OR register src_i into register dst_i and leaves the live mask unchanged.
- R7: Operation code 6 (loop-back) sets the live mask to the old mask AND NOT register src_i; taken_o is high in the same cycle exactly when that new mask is nonzero.
- R8: Operation code 7 (skip-if-zero) raises taken_o in the same cycle exactly when all 64 live mask bits are zero, and changes neither the mask nor any register.
- R9: Operation code 0 (no-op) changes neither the live mask nor any register even when dst_i is set, and taken_o is low for every code other than 6 and 7.
- R10: Every operation completes in one clock; all operand reads see the state from before the operation, including a register used as both source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded mask operation code |
| dst_i | input | 3 | Destination saved-mask register index |
| src_i | input | 3 | Source saved-mask register index |
| cond_i | input | 64 | Per-lane condition mask from vector compares |
| rd_idx_i | input | 3 | Saved-mask register read index |
| exec_o | output | 64 | Live execution mask |
| rd_mask_o | output | 64 | Contents of the register selected by rd_idx_i |
| taken_o | output | 1 | Branch-taken flag for loop-back and skip tests |

## Verification
The branch-taken flag is combinational from the operation, so the bench samples it one time unit after driving the inputs on the falling edge, before the rising edge that commits the update. The live mask and the written register become visible one rising edge later, so they are sampled one time unit after that edge, and the saved register is read through the combinational read port in the same window. Nested regions, loops that run to an empty mask, a condition that rejects every lane, and a source register that is also the destination all use this same schedule.

// File: rtl/emask_pkg.sv
package emask_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_IF    = 3'd1,
    OP_ELSE  = 3'd2,
    OP_END   = 3'd3,
    OP_BRK   = 3'd4,
    OP_IFBRK = 3'd5,
    OP_LOOP  = 3'd6,
    OP_SKIPZ = 3'd7
  } mask_op_e;
endpackage

// File: rtl/emask_alu.sv
module emask_alu
  import emask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  mask_op_e         op_i,
  input  logic [LANES-1:0] exec_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] src_i,
  output logic [LANES-1:0] exec_nxt_o,
  output logic             exec_we_o,
  output logic [LANES-1:0] wr_data_o,
  output logic             wr_en_o,
  output logic             taken_o
);
  logic [LANES-1:0] merged;

  assign merged = exec_i | src_i;

  always_comb begin
    exec_nxt_o = exec_i;
    exec_we_o  = 1'b0;
    wr_data_o  = '0;
    wr_en_o    = 1'b0;
    taken_o    = 1'b0;
    unique case (op_i)
      OP_IF: begin
        exec_nxt_o = exec_i & cond_i;
        exec_we_o  = 1'b1;
        wr_data_o  = exec_i & ~cond_i;
        wr_en_o    = 1'b1;
      end
      OP_ELSE: begin
        exec_nxt_o = merged ^ exec_i;
        exec_we_o  = 1'b1;
        wr_data_o  = merged;
        wr_en_o    = 1'b1;
      end
      OP_END: begin
        exec_nxt_o = merged;
        exec_we_o  = 1'b1;
      end
      OP_BRK: begin
        wr_data_o = merged;
        wr_en_o   = 1'b1;
      end
      OP_IFBRK: begin
        wr_data_o = cond_i | src_i;
        wr_en_o   = 1'b1;
      end
      OP_LOOP: begin
        exec_nxt_o = exec_i & ~src_i;
        exec_we_o  = 1'b1;
        taken_o    = |(exec_i & ~src_i);
      end
      OP_SKIPZ: taken_o = ~|exec_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/emask_regfile.sv
module emask_regfile #(
  parameter int LANES = 64,
  parameter int NREGS = 8,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDXW-1:0]  widx_i,
  input  logic [LANES-1:0] wdata_i,
  input  logic [IDXW-1:0]  ridx_a_i,
  output logic [LANES-1:0] rdata_a_o,
  input  logic [IDXW-1:0]  ridx_b_i,
  output logic [LANES-1:0] rdata_b_o
);
  logic [LANES-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs[g] <= '0;
      else if (we_i && widx_i == IDXW'(g))     regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[ridx_a_i];
  assign rdata_b_o = regs[ridx_b_i];
endmodule

// File: rtl/emask_exec_reg.sv
module emask_exec_reg #(
  parameter int LANES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/emask_ctrl.sv
module emask_ctrl
  import emask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int NREGS = 8,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [IDXW-1:0]  dst_i,
  input  logic [IDXW-1:0]  src_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [IDXW-1:0]  rd_idx_i,
  output logic [LANES-1:0] exec_o,
  output logic [LANES-1:0] rd_mask_o,
  output logic             taken_o
);
  logic [LANES-1:0] src_val, exec_nxt, wr_data;
  logic             exec_we, wr_en;

  emask_regfile #(.LANES(LANES), .NREGS(NREGS)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .widx_i    (dst_i),
    .wdata_i   (wr_data),
    .ridx_a_i  (src_i),
    .rdata_a_o (src_val),
    .ridx_b_i  (rd_idx_i),
    .rdata_b_o (rd_mask_o)
  );

  emask_alu #(.LANES(LANES)) i_alu (
    .op_i       (mask_op_e'(op_i)),
    .exec_i     (exec_o),
    .cond_i     (cond_i),
    .src_i      (src_val),
    .exec_nxt_o (exec_nxt),
    .exec_we_o  (exec_we),
    .wr_data_o  (wr_data),
    .wr_en_o    (wr_en),
    .taken_o    (taken_o)
  );

  emask_exec_reg #(.LANES(LANES)) i_exec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (exec_we),
    .d_i    (exec_nxt),
    .q_o    (exec_o)
  );
endmodule

// File: rtl/emask_ctrl_chk.sv
module emask_ctrl_chk #(
  parameter int LANES = 64,
  parameter int IDXW  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [LANES-1:0] cond_i,
  input logic [LANES-1:0] exec_o,
  input logic             taken_o
);
  // R2
  if_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd1 |=> exec_o == ($past(cond_i) & $past(exec_o)));
  // R4
  end_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd3 |=> (exec_o & $past(exec_o)) == $past(exec_o));
  // R5
  brk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd4 |=> $stable(exec_o));
  // R6
  ifbrk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd5 |=> $stable(exec_o));
  // R7
  loop_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd6 |=> (exec_o & ~$past(exec_o)) == '0);
  // R7
  loop_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd6 && taken_o) |=> exec_o != '0);
  // R7
  loop_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd6 && !taken_o) |=> exec_o == '0);
  // R8
  skipz_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd7 |-> taken_o == (exec_o == '0));
  // R8
  skipz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd7 |=> $stable(exec_o));
  // R9
  no_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 3'd6 && op_i != 3'd7) |-> !taken_o);
  // R9
  nop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd0 |=> $stable(exec_o));
endmodule

bind emask_ctrl emask_ctrl_chk #(.LANES(LANES), .IDXW(IDXW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .cond_i  (cond_i),
  .exec_o  (exec_o),
  .taken_o (taken_o)
);

// File: tb/test_emask_ctrl.sv
module test_emask_ctrl;
  localparam int LANES = 64;
  localparam int NREGS = 8;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  dst;
    logic [2:0]  src;
    logic [63:0] cond;
    logic [63:0] exp_exec;
    logic        exp_taken;
    logic [2:0]  chk_idx;
    logic [63:0] exp_reg;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    // R2 enter outer if
    '{3'd1, 3'd1, 3'd0, 64'h00FF00FF00FF00FF, 64'h00FF00FF00FF00FF, 1'b0, 3'd1, 64'hFF00FF00FF00FF00},
    // R2 nested if
    '{3'd1, 3'd2, 3'd0, 64'h0F0F0F0F0F0F0F0F, 64'h000F000F000F000F, 1'b0, 3'd2, 64'h00F000F000F000F0},
    // R3 R10 inner else, src == dst
    '{3'd2, 3'd2, 3'd2, 64'h0, 64'h00F000F000F000F0, 1'b0, 3'd2, 64'h00FF00FF00FF00FF},
    // R4 inner end
    '{3'd3, 3'd7, 3'd2, 64'h0, 64'h00FF00FF00FF00FF, 1'b0, 3'd7, 64'h0},
    // R3 outer else
    '{3'd2, 3'd1, 3'd1, 64'h0, 64'hFF00FF00FF00FF00, 1'b0, 3'd1, 64'hFFFFFFFFFFFFFFFF},
    // R4 outer end
    '{3'd3, 3'd7, 3'd1, 64'h0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 3'd7, 64'h0},
    // R2 loop region entry
    '{3'd1, 3'd4, 3'd0, 64'h00000000FFFFFFFF, 64'h00000000FFFFFFFF, 1'b0, 3'd4, 64'hFFFFFFFF00000000},
    // R6 conditional break
    '{3'd5, 3'd3, 3'd0, 64'h000000000000000F, 64'h00000000FFFFFFFF, 1'b0, 3'd3, 64'h000000000000000F},
    // R7 loop back, lanes remain
    '{3'd6, 3'd7, 3'd3, 64'h0, 64'h00000000FFFFFFF0, 1'b1, 3'd3, 64'h000000000000000F},
    // R5 break
    '{3'd4, 3'd5, 3'd3, 64'h0, 64'h00000000FFFFFFF0, 1'b0, 3'd5, 64'h00000000FFFFFFFF},
    // R7 loop back, mask empties
    '{3'd6, 3'd7, 3'd5, 64'h0, 64'h0, 1'b0, 3'd7, 64'h0},
    // R8 skip on empty mask
    '{3'd7, 3'd7, 3'd0, 64'h0, 64'h0, 1'b1, 3'd5, 64'h00000000FFFFFFFF},
    // R4 restore after loop
    '{3'd3, 3'd7, 3'd5, 64'h0, 64'h00000000FFFFFFFF, 1'b0, 3'd7, 64'h0},
    // R4 close loop region
    '{3'd3, 3'd7, 3'd4, 64'h0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 3'd7, 64'h0},
    // R8 skip not taken
    '{3'd7, 3'd7, 3'd0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 3'd7, 64'h0},
    // R9 nop with dst set
    '{3'd0, 3'd3, 3'd3, 64'h1234, 64'hFFFFFFFFFFFFFFFF, 1'b0, 3'd3, 64'h000000000000000F}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       op = '0, dst = '0, src = '0, rd_idx = '0;
  logic [63:0]      cond = '0;
  logic [63:0]      exec_mask, rd_mask;
  logic             taken;
  int               n_cmp = 0, n_bad = 0;
  bit               done = 1'b0;

  always #2.5ns clk = ~clk;

  emask_ctrl #(.LANES(LANES), .NREGS(NREGS)) i_emask_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_i      (op),
    .dst_i     (dst),
    .src_i     (src),
    .cond_i    (cond),
    .rd_idx_i  (rd_idx),
    .exec_o    (exec_mask),
    .rd_mask_o (rd_mask),
    .taken_o   (taken)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, flag before rising edge, state after it
  task automatic run_op(input logic [2:0] o, input logic [2:0] d, input logic [2:0] s,
                        input logic [63:0] c, input logic [63:0] x_exec, input logic x_taken,
                        input logic [2:0] ci, input logic [63:0] x_reg, input string req);
    @(negedge clk);
    op = o; dst = d; src = s; cond = c; rd_idx = ci;
    #1ns;
    check({req, " taken"}, {63'd0, taken}, {63'd0, x_taken});
    @(posedge clk);
    #1ns;
    check({req, " exec"}, exec_mask, x_exec);
    check({req, " reg"}, rd_mask, x_reg);
    @(negedge clk);
    op = '0;
  endtask

  initial begin
    #100us;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #12ns;
    // R1 reset state
    check("R1 exec", exec_mask, ONES);
    for (int i = 0; i < NREGS; i++) begin
      rd_idx = 3'(i);
      #1ns;
      check("R1 reg", rd_mask, 64'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      run_op(VECS[i].op, VECS[i].dst, VECS[i].src, VECS[i].cond,
             VECS[i].exp_exec, VECS[i].exp_taken, VECS[i].chk_idx, VECS[i].exp_reg, "table");

    // R2 condition rejects every lane
    run_op(3'd1, 3'd6, 3'd0, 64'h0, 64'h0, 1'b0, 3'd6, ONES, "R2 all fail");
    run_op(3'd7, 3'd7, 3'd0, 64'h0, 64'h0, 1'b1, 3'd6, ONES, "R8 empty skip");
    run_op(3'd3, 3'd7, 3'd6, 64'h0, ONES, 1'b0, 3'd6, ONES, "R4 restore all");
    // R7 loop back with empty break mask keeps all lanes
    run_op(3'd6, 3'd7, 3'd0, 64'h0, ONES, 1'b1, 3'd7, 64'h0, "R7 full loop");
    // R10 if writes old mask view into dst in the same clock
    run_op(3'd1, 3'd0, 3'd0, 64'h8000000000000001, 64'h8000000000000001, 1'b0,
           3'd0, 64'h7FFFFFFFFFFFFFFE, "R10 one clock");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    rd_idx = 3'd6;
    #1ns;
    check("R1 midrun exec", exec_mask, ONES);
    check("R1 midrun reg", rd_mask, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule